// File: doc/BRIEF.md
# Auto-Crossover Link Resolution Controller

This block brings one Ethernet LAN port up without software help. On a start pulse it waits a set number of clock ticks and then reads the PHY's basic status register through a management access register. That register is modelled as a request word going out and a status word coming back with a busy flag. While no link is reported, the block flips its crossover select output between straight (MDI) and crossed (MDIX) wiring after every failed poll. It tries again until a retry limit is used up.

Once link is seen, the controller walks a fixed chain of PHY register reads. It rereads status, then reads the vendor speed/duplex register. If auto-negotiation applies, it reads the expansion, local advertisement and partner advertisement registers. From these reads it builds a four-bit port configuration word. It writes that word once with a one-cycle strobe and then holds done. If the retry limit runs out, it holds fail instead. Both results stay until the next start.

Top module: `lan_link_resolver`

## Requirements
- R1: Each PHY read is one `acc_req` cycle. In that cycle `acc_word` carries 1 in bit 31 (request), 0 in bit 30 (read), `PHY_ADDR` in bits 25:21 and the register number in bits 20:16. All other bits are 0.
- R2: After a request the controller samples `acc_rdata[15:0]` only in a cycle where `acc_rdata[31]` (busy) is 0. It never raises `acc_req` while busy is 1. The bench holds busy for 3 cycles per read.
- R3: Link is polled by reading register 1, where bit 2 = 1 means link up. The first poll after start uses MDI (`xover_mdix` = 0). Every poll that sees bit 2 = 0 inverts `xover_mdix`, and nothing else changes it.
- R4: At least `DELAY_TICKS` cycles pass between start and the first link read request. The same minimum applies between a failed link poll's request and the next link read request.
- R5: After `LINK_TRIES` failed link polls, `fail` goes high, `done` stays low and `cfg_we` never pulses.
- R6: After link up, register 1 is read again. If its bit 5 is 0, the controller goes to done without pulsing `cfg_we`, and `cfg_word` stays 0.
- R7: If bit 5 is 1, register 31 is read. Its bits 4:2 give the speed code: 1 = 10 half, 5 = 10 full, 2 = 100 half, 6 = 100 full. In `cfg_word`, bit 1 marks full duplex and bit 2 marks 100 Mb/s.
- R8: Any other speed code leaves `cfg_word` bits 1 and 2 at 0. The run still completes with done and bit 0 set.
- R9: The pause chain runs in this order: status bit 3, register 6 bit 0, register 4 bit 10, register 5 bit 10. The chain stops at the first 0 and reads no further register. `cfg_word` bit 3 (pause) is set only when all four are 1.
- R10: `cfg_we` pulses for exactly one cycle per successful run, in the first cycle `done` is high. `cfg_word` bit 0 (link) is then 1, and the word holds afterwards.
- R11: `done` and `fail` are never high together. Each stays high until a start pulse, which is accepted only when idle, done or failed. The cycle after an accepted start has `done`, `fail`, `cfg_word` and `xover_mdix` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| start | input | 1 | Launch pulse |
| acc_req | output | 1 | Write strobe for the access word |
| acc_word | output | 32 | Management access word (request, read, PHY, register) |
| acc_rdata | input | 32 | Access register readback: bit 31 busy, bits 15:0 data |
| xover_mdix | output | 1 | Crossover select, 0 = MDI, 1 = MDIX |
| cfg_we | output | 1 | One-cycle write strobe for the configuration word |
| cfg_word | output | 4 | Bit 0 link, bit 1 full duplex, bit 2 100 Mb/s, bit 3 pause |
| done | output | 1 | Sticky success flag |
| fail | output | 1 | Sticky no-link flag |

## Verification
Some behaviour is checked by assertions on every cycle. These cover the access word format, the rule that no request is made while busy, the crossover output flipping only on a missed link poll, the single-cycle configuration strobe with the link bit set, and the clearing and stickiness of done and fail. Other behaviour can only be shown by the bench's scenarios. These include the exact order of register reads and where the pause chain stops, the decoded speed and duplex flags for each code, the MDI/MDIX sequence seen at each poll, the minimum poll spacing, and the fail outcome after the retry limit.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ISSUE, ST_POLL, ST_COMMIT, ST_DONE, ST_FAIL
  } lrc_state_t;

  typedef enum logic [2:0] {
    RD_LINK, RD_STAT, RD_SPEED, RD_ANX, RD_ADV, RD_LPADV
  } lrc_step_t;

  localparam int CFG_W      = 4;
  localparam int CFG_LINK   = 0;
  localparam int CFG_DUPLEX = 1;
  localparam int CFG_FAST   = 2;
  localparam int CFG_PAUSE  = 3;

  // PHY register number read in each step of the chain
  function automatic logic [4:0] step_regnum(lrc_step_t s);
    case (s)
      RD_LINK, RD_STAT: return 5'd1;
      RD_SPEED:         return 5'd31;
      RD_ANX:           return 5'd6;
      RD_ADV:           return 5'd4;
      RD_LPADV:         return 5'd5;
      default:          return 5'd1;
    endcase
  endfunction

  function automatic logic [31:0] access_word(logic [4:0] phy, logic [4:0] regnum);
    logic [31:0] w;
    w        = '0;
    w[31]    = 1'b1;
    w[30]    = 1'b0;
    w[25:21] = phy;
    w[20:16] = regnum;
    return w;
  endfunction

  // returns {fast, duplex}
  function automatic logic [1:0] speed_flags(logic [2:0] code);
    case (code)
      3'd1:    return 2'b00;
      3'd5:    return 2'b01;
      3'd2:    return 2'b10;
      3'd6:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/lrc_tick_timer.sv
module lrc_tick_timer #(
  parameter int TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expired
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (arm)          cnt <= CW'(TICKS);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/lrc_try_counter.sv
module lrc_try_counter #(
  parameter int TRIES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(TRIES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (bump)   cnt <= cnt + CW'(1);
  end

  assign last = (cnt == CW'(TRIES - 1));
endmodule

// File: rtl/lan_link_resolver.sv
module lan_link_resolver
  import lrc_pkg::*;
#(
  parameter int PHY_ADDR    = 6,
  parameter int DELAY_TICKS = 1000,
  parameter int LINK_TRIES  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              acc_req,
  output logic [31:0]       acc_word,
  input  logic [31:0]       acc_rdata,
  output logic              xover_mdix,
  output logic              cfg_we,
  output logic [CFG_W-1:0]  cfg_word,
  output logic              done,
  output logic              fail
);

  lrc_state_t state;
  lrc_step_t  step;
  logic       an_able, dl, sl, pl, xover_q, cfg_we_q;
  logic [CFG_W-1:0] cfg_q;

  // named internal events
  logic        launch, acc_busy, rd_valid, link_miss, tmr_expired, tries_last;
  logic [15:0] rd_data;
  logic        unused_bits;

  assign acc_busy  = acc_rdata[31];
  assign rd_data   = acc_rdata[15:0];
  assign launch    = start && (state == ST_IDLE || state == ST_DONE || state == ST_FAIL);
  assign rd_valid  = (state == ST_POLL) && !acc_busy;
  assign link_miss = rd_valid && (step == RD_LINK) && !rd_data[2];
  assign unused_bits = ^{acc_rdata[30:16], rd_data[15:11], rd_data[9:6], rd_data[1]};

  lrc_tick_timer #(.TICKS(DELAY_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (launch || (link_miss && !tries_last)),
    .expired (tmr_expired)
  );

  lrc_try_counter #(.TRIES(LINK_TRIES)) u_tries (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (launch),
    .bump  (link_miss),
    .last  (tries_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step     <= RD_LINK;
      an_able  <= 1'b0;
      dl       <= 1'b0;
      sl       <= 1'b0;
      pl       <= 1'b0;
      xover_q  <= 1'b0;
      cfg_q    <= '0;
      cfg_we_q <= 1'b0;
    end else begin
      cfg_we_q <= (state == ST_COMMIT);
      if (launch) begin
        state   <= ST_WAIT;
        step    <= RD_LINK;
        an_able <= 1'b0;
        dl      <= 1'b0;
        sl      <= 1'b0;
        pl      <= 1'b0;
        xover_q <= 1'b0;
        cfg_q   <= '0;
      end else begin
        case (state)
          ST_WAIT:  if (tmr_expired) state <= ST_ISSUE;
          ST_ISSUE: state <= ST_POLL;
          ST_POLL: if (rd_valid) begin
            case (step)
              RD_LINK: begin
                if (rd_data[2]) begin
                  step  <= RD_STAT;
                  state <= ST_ISSUE;
                end else begin
                  xover_q <= ~xover_q;
                  state   <= tries_last ? ST_FAIL : ST_WAIT;
                end
              end
              RD_STAT: begin
                an_able <= rd_data[3];
                if (rd_data[5]) begin
                  step  <= RD_SPEED;
                  state <= ST_ISSUE;
                end else begin
                  state <= ST_DONE;
                end
              end
              RD_SPEED: begin
                {sl, dl} <= speed_flags(rd_data[4:2]);
                if (an_able) begin
                  step  <= RD_ANX;
                  state <= ST_ISSUE;
                end else begin
                  state <= ST_COMMIT;
                end
              end
              RD_ANX: begin
                if (rd_data[0]) begin
                  step  <= RD_ADV;
                  state <= ST_ISSUE;
                end else begin
                  state <= ST_COMMIT;
                end
              end
              RD_ADV: begin
                if (rd_data[10]) begin
                  step  <= RD_LPADV;
                  state <= ST_ISSUE;
                end else begin
                  state <= ST_COMMIT;
                end
              end
              RD_LPADV: begin
                pl    <= rd_data[10];
                state <= ST_COMMIT;
              end
              default: state <= ST_FAIL;
            endcase
          end
          ST_COMMIT: begin
            cfg_q[CFG_LINK]   <= 1'b1;
            cfg_q[CFG_DUPLEX] <= dl;
            cfg_q[CFG_FAST]   <= sl;
            cfg_q[CFG_PAUSE]  <= pl;
            state             <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign acc_req    = (state == ST_ISSUE);
  assign acc_word   = access_word(5'(PHY_ADDR), step_regnum(step));
  assign xover_mdix = xover_q;
  assign cfg_we     = cfg_we_q;
  assign cfg_word   = cfg_q;
  assign done       = (state == ST_DONE);
  assign fail       = (state == ST_FAIL);

endmodule

// File: rtl/lrc_checker.sv
module lrc_checker #(
  parameter int PHY_ADDR = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        acc_req,
  input logic [31:0] acc_word,
  input logic [31:0] acc_rdata,
  input logic        xover_mdix,
  input logic        cfg_we,
  input logic [3:0]  cfg_word,
  input logic        done,
  input logic        fail,
  input logic        launch,
  input logic        link_miss
);

  AST_REQ_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> (acc_word[31] && !acc_word[30] && acc_word[25:21] == 5'(PHY_ADDR)
                 && acc_word[29:26] == 4'd0 && acc_word[15:0] == 16'd0)); // R1

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> !acc_req); // R1

  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> !acc_rdata[31]); // R2

  AST_XOVER_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (link_miss && !launch) |=> (xover_mdix != $past(xover_mdix))); // R3

  AST_XOVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_miss && !launch) |=> $stable(xover_mdix)); // R3

  AST_CFG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !cfg_we); // R10

  AST_CFG_LINK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (cfg_word[0] && done)); // R10

  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R11

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R11

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail); // R11

  AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (!done && !fail && !xover_mdix && cfg_word == 4'd0)); // R11

endmodule

bind lan_link_resolver lrc_checker #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .acc_req    (acc_req),
  .acc_word   (acc_word),
  .acc_rdata  (acc_rdata),
  .xover_mdix (xover_mdix),
  .cfg_we     (cfg_we),
  .cfg_word   (cfg_word),
  .done       (done),
  .fail       (fail),
  .launch     (launch),
  .link_miss  (link_miss)
);

// File: tb/lan_link_resolver_test.sv
module lan_link_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int PHY_A      = 6;
  localparam int DLY        = 8;
  localparam int TRIES      = 4;
  localparam int BUSY_LAT   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        acc_req;
  logic [31:0] acc_word;
  logic [31:0] acc_rdata;
  logic        xover_mdix;
  logic        cfg_we;
  logic [3:0]  cfg_word;
  logic        done;
  logic        fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  lan_link_resolver #(.PHY_ADDR(PHY_A), .DELAY_TICKS(DLY), .LINK_TRIES(TRIES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .acc_req(acc_req), .acc_word(acc_word), .acc_rdata(acc_rdata),
    .xover_mdix(xover_mdix), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .done(done), .fail(fail)
  );

  // PHY scenario knobs
  int         link_at = 1;
  logic       st_b5 = 1'b1, st_b3 = 1'b1, p6 = 1'b1, p4 = 1'b1, p5 = 1'b1;
  logic [2:0] spd = 3'd6;
  logic       mon_clr = 1'b0;

  // PHY access model and monitors
  logic        rbusy;
  int          lat;
  logic [15:0] rdata;
  int          n_link, nreads, ncfg, cyc, start_cyc, last_req, min_gap, first_gap;
  logic        seen_first, prev_miss, fmt_bad;
  logic [63:0] sig;
  logic [15:0] xlog;
  logic [3:0]  cfg_cap;
  logic [4:0]  rn;
  logic        link_now;

  assign acc_rdata = {rbusy, 15'd0, rdata};
  assign rn        = acc_word[20:16];
  assign link_now  = (n_link + 1 >= link_at);

  always @(posedge clk) cyc <= cyc + 1;
  initial cyc = 0;

  always @(posedge clk) begin
    if (!rst_n || mon_clr) begin
      rbusy <= 1'b0; lat <= 0; rdata <= 16'd0; n_link <= 0; nreads <= 0;
      ncfg <= 0; cfg_cap <= 4'd0; sig <= 64'd0; xlog <= 16'd0;
      min_gap <= 99999; last_req <= 0; first_gap <= 0; start_cyc <= 0;
      seen_first <= 1'b0; prev_miss <= 1'b0; fmt_bad <= 1'b0;
    end else begin
      if (start) start_cyc <= cyc;
      if (acc_req) begin
        rbusy  <= 1'b1;
        lat    <= BUSY_LAT;
        nreads <= nreads + 1;
        sig    <= {sig[58:0], rn};
        if (acc_word[31:30] != 2'b10 || acc_word[25:21] != 5'(PHY_A)) fmt_bad <= 1'b1;
        case (rn)
          5'd1: begin
            rdata  <= {10'd0, st_b5, 1'b0, st_b3, link_now, 2'b11};
            n_link <= n_link + 1;
            xlog   <= {xlog[14:0], xover_mdix};
            if (!seen_first) first_gap <= cyc - start_cyc;
            else if (prev_miss && (cyc - last_req < min_gap)) min_gap <= cyc - last_req;
            seen_first <= 1'b1;
            prev_miss  <= !link_now;
            last_req   <= cyc;
          end
          5'd31: rdata <= 16'hFFE3 | {11'd0, spd, 2'b00};
          5'd6:  rdata <= {15'h2AAA, p6};
          5'd4:  rdata <= {5'b11111, p4, 10'h3FF};
          5'd5:  rdata <= {5'b00000, p5, 10'h155};
          default: rdata <= 16'd0;
        endcase
      end else if (lat != 0) begin
        lat <= lat - 1;
        if (lat == 1) rbusy <= 1'b0;
      end
      if (cfg_we) begin
        ncfg    <= ncfg + 1;
        cfg_cap <= cfg_word;
      end
    end
  end

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic launch_run(input int la, input logic b5, input logic b3, input logic [2:0] code,
                            input logic q6, input logic q4, input logic q5);
    link_at = la; st_b5 = b5; st_b3 = b3; spd = code; p6 = q6; p4 = q4; p5 = q5;
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R11", "cleared after start", {60'd0, done, fail, xover_mdix, 1'b0} | {60'd0, cfg_word}, 64'd0);
    for (int i = 0; i < 3000; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
    if (!(done || fail)) check("R5", "run ended", 64'd0, 64'd1);
    for (int i = 0; i < 4; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11", "reset done", {63'd0, done}, 64'd0);
    check("R11", "reset fail", {63'd0, fail}, 64'd0);
    check("R3",  "reset xover", {63'd0, xover_mdix}, 64'd0);
    check("R10", "reset cfg", {60'd0, cfg_word}, 64'd0);
    check("R1",  "reset req", {63'd0, acc_req}, 64'd0);
  endtask

  task automatic t_first_try_full;  // link on first poll, 100 full, pause agreed
    launch_run(1, 1, 1, 3'd6, 1, 1, 1);
    check("R10", "done", {63'd0, done}, 64'd1);
    check("R7",  "cfg 100F pause", {60'd0, cfg_cap}, 64'hF);
    check("R9",  "read order", sig, 64'({5'd1, 5'd1, 5'd31, 5'd6, 5'd4, 5'd5}));
    check("R10", "one write", 64'(ncfg), 64'd1);
    check("R10", "word held", {60'd0, cfg_word}, 64'hF);
    check("R1",  "word format", {63'd0, fmt_bad}, 64'd0);
    check("R4",  "first poll spacing ok", {63'd0, first_gap >= DLY}, 64'd1);
  endtask

  task automatic t_third_try_10h;   // crossover alternation, no AN
    launch_run(3, 1, 0, 3'd1, 1, 1, 1);
    check("R3",  "xover at polls", {48'd0, xlog}, 64'b0100);
    check("R3",  "final xover MDI", {63'd0, xover_mdix}, 64'd0);
    check("R7",  "cfg 10H", {60'd0, cfg_cap}, 64'h1);
    check("R9",  "no AN chain", sig, 64'({5'd1, 5'd1, 5'd1, 5'd1, 5'd31}));
    check("R4",  "poll spacing", {63'd0, min_gap >= DLY}, 64'd1);
    check("R2",  "reads counted", 64'(nreads), 64'd5);
  endtask

  task automatic t_100h_partner_no_an;
    launch_run(2, 1, 1, 3'd2, 0, 1, 1);
    check("R3", "xover at polls", {48'd0, xlog}, 64'b011);
    check("R3", "final xover MDIX", {63'd0, xover_mdix}, 64'd1);
    check("R7", "cfg 100H", {60'd0, cfg_cap}, 64'h5);
    check("R9", "stop after reg6", sig, 64'({5'd1, 5'd1, 5'd1, 5'd31, 5'd6}));
  endtask

  task automatic t_10f_no_local_pause;
    launch_run(1, 1, 1, 3'd5, 1, 0, 1);
    check("R7", "cfg 10F", {60'd0, cfg_cap}, 64'h3);
    check("R9", "stop after reg4", sig, 64'({5'd1, 5'd1, 5'd31, 5'd6, 5'd4}));
  endtask

  task automatic t_partner_no_pause;
    launch_run(1, 1, 1, 3'd6, 1, 1, 0);
    check("R9", "no pause", {60'd0, cfg_cap}, 64'h7);
    check("R9", "full chain", sig, 64'({5'd1, 5'd1, 5'd31, 5'd6, 5'd4, 5'd5}));
  endtask

  task automatic t_bad_speed_code;
    launch_run(1, 1, 1, 3'd3, 1, 1, 1);
    check("R8", "unknown code", {60'd0, cfg_cap}, 64'h9);
    check("R8", "done", {63'd0, done}, 64'd1);
  endtask

  task automatic t_an_incomplete;
    launch_run(1, 0, 1, 3'd6, 1, 1, 1);
    check("R6", "done", {63'd0, done}, 64'd1);
    check("R6", "no write", 64'(ncfg), 64'd0);
    check("R6", "word zero", {60'd0, cfg_word}, 64'd0);
    check("R6", "stop after reread", sig, 64'({5'd1, 5'd1}));
  endtask

  task automatic t_no_link;
    launch_run(1000, 1, 1, 3'd6, 1, 1, 1);
    check("R5", "fail", {63'd0, fail}, 64'd1);
    check("R5", "not done", {63'd0, done}, 64'd0);
    check("R5", "no write", 64'(ncfg), 64'd0);
    check("R5", "polls", sig, 64'({5'd1, 5'd1, 5'd1, 5'd1}));
    check("R3", "xover at polls", {48'd0, xlog}, 64'b0101);
    for (int i = 0; i < 20; i++) @(negedge clk);
    check("R11", "fail sticky", {62'd0, done, fail}, 64'b01);
  endtask

  task automatic t_restart_after_fail;
    launch_run(1, 1, 1, 3'd6, 1, 1, 1);
    check("R11", "restart ok", {62'd0, done, fail}, 64'b10);
    check("R11", "cfg rewritten", {60'd0, cfg_cap}, 64'hF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_try_full();
    t_third_try_10h();
    t_100h_partner_no_an();
    t_10f_no_local_pause();
    t_partner_no_pause();
    t_bad_speed_code();
    t_an_incomplete();
    t_no_link();
    t_restart_after_fail();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule